// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Result Registers

This block sits beside an integer pipeline and performs 32-bit multiply and divide operations, signed or unsigned. The result goes to a pair of private result registers: HI for the upper half or the remainder, and LO for the lower half or the quotient. An accepted multiply or divide occupies the unit for a fixed number of cycles. During that time `busy_o` is high, and a read request on the HI/LO read port is held off with `rd_valid_o` low until the new values are in place. Move-to-HI and move-to-LO commands load a register directly from operand A in one cycle.

Division by zero never traps. It gives a fixed result that depends on the signedness and on the sign of the dividend. The signed overflow case, the most negative value divided by minus one, wraps to the most negative value with a zero remainder.

The control is a two-state machine. In `ST_IDLE` the unit waits. An accepted arithmetic start (transition *launch*) captures the result and enters `ST_RUN` with a down-counter loaded from the operation's latency. Each cycle in `ST_RUN` decrements the counter (transition *count*). When the counter reaches zero, the *retire* transition writes HI/LO and returns to `ST_IDLE`. Move commands and unused codes take the *idle-hold* transition and never leave `ST_IDLE`.

Top module: `muldiv_unit`

## Requirements
- R1: Op code 0 (signed multiply) sign-extends both operands, forms the 64-bit product, and places its upper 32 bits in HI and its lower 32 bits in LO.
- R2: Op code 1 (unsigned multiply) zero-extends both operands and splits the 64-bit product the same way as R1.
- R3: Op code 2 (signed divide) with a non-zero divisor truncates toward zero. It puts the quotient in LO and the remainder in HI, and the remainder takes the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives LO=0x80000000 and HI=0.
- R4: Op code 3 (unsigned divide) with a non-zero divisor puts the unsigned quotient in LO and the remainder in HI.
- R5: A signed divide by zero sets HI to the dividend. It sets LO to 0xFFFFFFFF when the dividend's bit 31 is 0, and to 1 when bit 31 is 1.
- R6: An unsigned divide by zero sets HI to the dividend and LO to 0xFFFFFFFF.
- R7: An accepted multiply holds `busy_o` high for exactly MUL_LAT (default 5) cycles after the accepting clock edge. The new HI/LO are readable in the first cycle after `busy_o` falls.
- R8: An accepted divide holds `busy_o` high for exactly DIV_LAT (default 10) cycles after the accepting clock edge.
- R9: Op code 4 loads HI and op code 5 loads LO from `opa_i` at the accepting edge, without raising `busy_o`. Op codes 6 and 7 change neither register nor `busy_o`.
- R10: `rd_valid_o` is high exactly when `rd_req_i` is high and `busy_o` is low. `rd_data_o` shows HI when `rd_sel_i`=1 and LO when `rd_sel_i`=0.
- R11: A start request while `busy_o` is high is ignored. It does not change the running operation, its latency or its result, and HI/LO stay unchanged while busy.
- R12: After reset HI and LO are 0 and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command request, taken only while idle |
| op_i | input | 3 | Command code (0..7, see R1–R9) |
| opa_i | input | WIDTH | Operand A: multiplicand, dividend, or move source |
| opb_i | input | WIDTH | Operand B: multiplier or divisor |
| busy_o | output | 1 | An arithmetic operation is in flight |
| rd_req_i | input | 1 | Request to read HI or LO |
| rd_sel_i | input | 1 | Read select: 1 for HI, 0 for LO |
| rd_valid_o | output | 1 | Read data is valid this cycle (request not stalled) |
| rd_data_o | output | WIDTH | Selected result register |

## Verification
`busy_o` is first seen high one cycle after the accepting edge, because one state register lies between them. The bench samples at the falling edge and counts busy cycles until `busy_o` drops. It expects MUL_LAT or DIV_LAT cycles in total, and only then reads HI and LO, whose read path is combinational from the result registers. A move command is due one edge after it is accepted, so the bench reads it at the next falling edge. A stall is checked in the cycle right after launch, with the read request held high. Expected products, quotients and remainders are computed in the bench with 64-bit integer arithmetic over a grid of corner-case operands.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    typedef enum logic [2:0] {
        OP_MUL_S  = 3'd0,
        OP_MUL_U  = 3'd1,
        OP_DIV_S  = 3'd2,
        OP_DIV_U  = 3'd3,
        OP_SET_HI = 3'd4,
        OP_SET_LO = 3'd5,
        OP_NONE_A = 3'd6,
        OP_NONE_B = 3'd7
    } mdu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mdu_state_e;
endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic               signed_i,
    output logic [2*WIDTH-1:0] prod_o
);
    logic [2*WIDTH-1:0] ext_a;
    logic [2*WIDTH-1:0] ext_b;

    // Extend both operands to full product width, then keep the low half of the product.
    always_comb begin
        ext_a  = {{WIDTH{signed_i & a_i[WIDTH-1]}}, a_i};
        ext_b  = {{WIDTH{signed_i & b_i[WIDTH-1]}}, b_i};
        prod_o = ext_a * ext_b;
    end
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             signed_i,
    output logic [WIDTH-1:0] quo_o,
    output logic [WIDTH-1:0] rem_o
);
    logic             neg_a;
    logic             neg_b;
    logic [WIDTH-1:0] mag_a;
    logic [WIDTH-1:0] mag_b;
    logic [WIDTH-1:0] q_mag;
    logic [WIDTH-1:0] r_mag;

    // Divide magnitudes unsigned, then restore signs (truncating division).
    always_comb begin
        neg_a = signed_i & a_i[WIDTH-1];
        neg_b = signed_i & b_i[WIDTH-1];
        mag_a = neg_a ? (~a_i + 1'b1) : a_i;
        mag_b = neg_b ? (~b_i + 1'b1) : b_i;
        q_mag = '0;
        r_mag = '0;
        if (b_i == '0) begin
            // Fixed, non-trapping result for a zero divisor.
            rem_o = a_i;
            quo_o = neg_a ? {{(WIDTH-1){1'b0}}, 1'b1} : {WIDTH{1'b1}};
        end else begin
            q_mag = mag_a / mag_b;
            r_mag = mag_a % mag_b;
            quo_o = (neg_a ^ neg_b) ? (~q_mag + 1'b1) : q_mag;
            rem_o = neg_a ? (~r_mag + 1'b1) : r_mag;
        end
    end
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
    import muldiv_pkg::*;
#(
    parameter int MUL_LAT = 5,
    parameter int DIV_LAT = 10
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  mdu_op_e op_i,
    output logic    busy_o,
    output logic    capture_o,
    output logic    commit_o,
    output logic    set_hi_o,
    output logic    set_lo_o
);
    localparam int MAXL = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
    localparam int CW   = $clog2(MAXL + 1);

    mdu_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          is_arith;
    logic          accept;

    assign is_arith = (op_i[2] == 1'b0);
    assign accept   = start_i && (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: launch, count, retire, idle-hold
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && is_arith) begin
                    state_d = ST_RUN;
                    cnt_d   = (op_i == OP_DIV_S || op_i == OP_DIV_U) ?
                              CW'(DIV_LAT - 1) : CW'(MUL_LAT - 1);
                end
            end
            ST_RUN: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy_o    = 1'b0;
        capture_o = 1'b0;
        commit_o  = 1'b0;
        set_hi_o  = 1'b0;
        set_lo_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                capture_o = accept && is_arith;
                set_hi_o  = accept && (op_i == OP_SET_HI);
                set_lo_o  = accept && (op_i == OP_SET_LO);
            end
            ST_RUN: begin
                busy_o   = 1'b1;
                commit_o = (cnt_q == '0);
            end
        endcase
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int MUL_LAT = 5,
    parameter int DIV_LAT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic             busy_o,
    input  logic             rd_req_i,
    input  logic             rd_sel_i,
    output logic             rd_valid_o,
    output logic [WIDTH-1:0] rd_data_o
);
    mdu_op_e            op;
    logic               capture, commit, set_hi, set_lo;
    logic [2*WIDTH-1:0] prod;
    logic [WIDTH-1:0]   quo, rem;
    logic [2*WIDTH-1:0] res_d, res_q;
    logic [WIDTH-1:0]   hi_q, lo_q;

    assign op = mdu_op_e'(op_i);

    muldiv_seq #(.MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op),
        .busy_o    (busy_o),
        .capture_o (capture),
        .commit_o  (commit),
        .set_hi_o  (set_hi),
        .set_lo_o  (set_lo)
    );

    muldiv_mul #(.WIDTH(WIDTH)) u_mul (
        .a_i      (opa_i),
        .b_i      (opb_i),
        .signed_i (op == OP_MUL_S),
        .prod_o   (prod)
    );

    muldiv_div #(.WIDTH(WIDTH)) u_div (
        .a_i      (opa_i),
        .b_i      (opb_i),
        .signed_i (op == OP_DIV_S),
        .quo_o    (quo),
        .rem_o    (rem)
    );

    // Pending result is {HI, LO}; op code bit 1 marks a divide.
    assign res_d = op_i[1] ? {rem, quo} : prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else begin
            if (capture) res_q <= res_d;
            if (commit) begin
                hi_q <= res_q[2*WIDTH-1:WIDTH];
                lo_q <= res_q[WIDTH-1:0];
            end
            if (set_hi) hi_q <= opa_i;
            if (set_lo) lo_q <= opa_i;
        end
    end

    assign rd_valid_o = rd_req_i && !busy_o;
    assign rd_data_o  = rd_sel_i ? hi_q : lo_q;
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
    parameter int WIDTH   = 32,
    parameter int MUL_LAT = 5,
    parameter int DIV_LAT = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] opa_i,
    input logic             busy_o,
    input logic             rd_req_i,
    input logic             rd_valid_o,
    input logic [WIDTH-1:0] hi_q,
    input logic [WIDTH-1:0] lo_q
);
    int run_len;
    int exp_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= 0;
            exp_len <= 0;
        end else if (start_i && !busy_o && !op_i[2]) begin
            run_len <= 0;
            exp_len <= op_i[1] ? DIV_LAT : MUL_LAT;
        end else if (busy_o) begin
            run_len <= run_len + 1;
        end
    end

    // R7 and R8: busy length matches the launched operation
    a_r7_r8_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> run_len == exp_len);

    a_r7_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !op_i[2]) |=> busy_o);

    a_r9_set_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i == 3'd4) |=> (hi_q == $past(opa_i) && !busy_o));

    a_r9_set_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i == 3'd5) |=> (lo_q == $past(opa_i) && !busy_o));

    a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !rd_valid_o);

    a_r10_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && !busy_o) |-> rd_valid_o);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind muldiv_unit muldiv_chk #(.WIDTH(WIDTH), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_i       (op_i),
    .opa_i      (opa_i),
    .busy_o     (busy_o),
    .rd_req_i   (rd_req_i),
    .rd_valid_o (rd_valid_o),
    .hi_q       (hi_q),
    .lo_q       (lo_q)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
    localparam int MUL_LAT = 5;
    localparam int DIV_LAT = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        busy_o;
    logic        rd_req_i = 1'b0;
    logic        rd_sel_i = 1'b0;
    logic        rd_valid_o;
    logic [31:0] rd_data_o;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    muldiv_unit #(.WIDTH(32), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o),
        .rd_req_i(rd_req_i), .rd_sel_i(rd_sel_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
    );

    task automatic check(input bit ok, input string req, input longint got, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic read_reg(input bit sel, output logic [31:0] val, output logic vld);
        rd_req_i = 1'b1;
        rd_sel_i = sel;
        #1;
        val = rd_data_o;
        vld = rd_valid_o;
        rd_req_i = 1'b0;
    endtask

    task automatic expect_hilo(input logic [31:0] eh, input logic [31:0] el, input string req);
        logic [31:0] v;
        logic        vl;
        read_reg(1'b1, v, vl);
        check(vl === 1'b1 && v === eh, {req, " HI"}, longint'(v), longint'(eh));
        read_reg(1'b0, v, vl);
        check(vl === 1'b1 && v === el, {req, " LO"}, longint'(v), longint'(el));
    endtask

    function automatic void model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] eh, output logic [31:0] el);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint unsigned ua = 64'(a);
        longint unsigned ub = 64'(b);
        longint p;
        case (op)
            3'd0: begin p = sa * sb; eh = p[63:32]; el = p[31:0]; end
            3'd1: begin p = longint'(ua * ub); eh = p[63:32]; el = p[31:0]; end
            3'd2: begin
                if (b == 0) begin eh = a; el = a[31] ? 32'd1 : 32'hFFFF_FFFF; end
                else begin p = sa / sb; el = p[31:0]; p = sa % sb; eh = p[31:0]; end
            end
            default: begin
                if (b == 0) begin eh = a; el = 32'hFFFF_FFFF; end
                else begin el = a / b; eh = a % b; end
            end
        endcase
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] eh, el;
        int          n;
        int          lat;
        string       rq;
        model(op, a, b, eh, el);
        lat = op[1] ? DIV_LAT : MUL_LAT;
        case (op)
            3'd0: rq = "R1";
            3'd1: rq = "R2";
            3'd2: rq = (b == 0) ? "R5" : "R3";
            default: rq = (b == 0) ? "R6" : "R4";
        endcase
        @(negedge clk);
        start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (busy_o === 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
        check(n == lat, op[1] ? "R8 latency" : "R7 latency", longint'(n), longint'(lat));
        expect_hilo(eh, el, rq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] vals [8];
        logic [31:0] v;
        logic        vl;
        int          n;
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
        vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h0000_0007;
        vals[4] = 32'hFFFF_FFF9; vals[5] = 32'h8000_0000;
        vals[6] = 32'h7FFF_FFFF; vals[7] = 32'h1234_5678;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(busy_o === 1'b0, "R12 busy", longint'(busy_o), 0);
        expect_hilo(32'h0, 32'h0, "R12");

        // R1..R8 sweep
        for (int op = 0; op < 4; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_op(3'(op), vals[i], vals[j]);

        // R3 overflow corner explicitly
        run_op(3'd2, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op(3'd2, 32'hFFFF_FFF9, 32'h0000_0002);

        // R9 moves
        @(negedge clk);
        start_i = 1'b1; op_i = 3'd4; opa_i = 32'hCAFE_0001;
        @(negedge clk);
        op_i = 3'd5; opa_i = 32'hBEEF_0002;
        check(busy_o === 1'b0, "R9 no busy", longint'(busy_o), 0);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b0, "R9 no busy", longint'(busy_o), 0);
        expect_hilo(32'hCAFE_0001, 32'hBEEF_0002, "R9");
        for (int c = 6; c < 8; c++) begin
            @(negedge clk);
            start_i = 1'b1; op_i = 3'(c); opa_i = 32'h5555_5555; opb_i = 32'h3;
            @(negedge clk);
            start_i = 1'b0;
            check(busy_o === 1'b0, "R9 unused code busy", longint'(busy_o), 0);
            expect_hilo(32'hCAFE_0001, 32'hBEEF_0002, "R9 unused code");
        end

        // R10 stall and R11 start-while-busy
        @(negedge clk);
        start_i = 1'b1; op_i = 3'd1; opa_i = 32'd3; opb_i = 32'd5;
        @(negedge clk);
        op_i = 3'd3; opa_i = 32'd100; opb_i = 32'd7;
        read_reg(1'b1, v, vl);
        check(vl === 1'b0, "R10 stall valid", longint'(vl), 0);
        check(v === 32'hCAFE_0001, "R11 HI held", longint'(v), longint'(32'hCAFE_0001));
        n = 1;
        @(negedge clk);
        op_i = 3'd4; opa_i = 32'hDEAD_DEAD;
        n++;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o === 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
        check(n == MUL_LAT, "R11 latency", longint'(n), longint'(MUL_LAT));
        expect_hilo(32'h0, 32'd15, "R11");
        read_reg(1'b0, v, vl);
        check(vl === 1'b1, "R10 valid when idle", longint'(vl), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule